// File: doc/BRIEF.md
# Display RAM Write Packer

This block sits between a display command interface and a 32-column by 4-row display memory. Each column holds one 4-bit word, one bit per backplane row. The block takes one data byte per strobe, cuts it into groups whose size depends on the multiplex setting, and issues one masked word write per clock cycle. Each write goes to the address held in an internal pointer, and the pointer steps after every write. A run of bytes therefore fills consecutive columns with no software help.

The multiplex setting decides how many rows take part in each write: one, two, three or four. Bits are consumed from the most significant end of the byte. The first bit of each group lands on the lowest row in use. With one or two rows in use, a bank input can move the target rows up by two. Each write carries a per-row enable, so bits that are not being written keep their value in the memory. The memory itself, the serial front end and command decoding live elsewhere.

Top module: `dram_packer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `wr_en` is 0 and `ptr` is 0.
- R2: With `mode`=0 (one row), a byte is written as eight single-bit writes to row 0 at eight successive addresses, taking bit 7 first.
- R3: With `mode`=1 (two rows), a byte is written as four writes at successive addresses. Write k puts bit 7-2k on row 0 and bit 6-2k on row 1.
- R4: With `mode`=2 (three rows), a byte is written as three writes. The first two carry bits 7,6,5 and then 4,3,2 on rows 0,1,2. The third carries bits 1,0 on rows 0,1 and enables neither row 2 nor row 3.
- R5: With `mode`=3 (four rows), a byte is written as two writes. They carry bits 7..4 and then 3..0 on rows 0..3.
- R6: With `bank_sel`=1, mode 0 writes row 2 instead of row 0, and mode 1 writes rows 2,3 instead of rows 0,1. In modes 2 and 3, `bank_sel` has no effect.
- R7: Each write uses the current pointer value as `wr_addr`, and the pointer then steps by one, wrapping from 31 to 0. `ptr` always shows the address the next write will use.
- R8: `ptr_load` sets the pointer to `ptr_start` and takes priority over stepping. If a strobe arrives in the same cycle as a load, its byte starts at the loaded address. A load while a byte is being unpacked redirects the writes that remain.
- R9: Only rows whose `wr_en` bit is 1 are written, and `wr_data` is 0 on every row that is not enabled. All other memory bits keep their values.
- R10: The multiplex setting and the bank choice are captured with the byte. Changing `mode` or `bank_sel` while a byte is being unpacked does not affect that byte.
- R11: A strobe that arrives while any write of the previous byte is still pending is dropped.
- R12: The first write of a byte appears on the outputs two clock edges after the strobe edge is sampled, and the later writes follow on successive cycles with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Strobe for one data byte |
| byte_data | input | 8 | Data byte to pack |
| ptr_load | input | 1 | Load the address pointer |
| ptr_start | input | 5 | Address loaded into the pointer |
| mode | input | 2 | Rows per write minus one (0..3) |
| bank_sel | input | 1 | Move the target rows up by two in modes 0 and 1 |
| wr_en | output | 4 | Per-row write enable for the memory |
| wr_addr | output | 5 | Column address of the write |
| wr_data | output | 4 | Per-row write data, 0 where not enabled |
| ptr | output | 5 | Address the next write will use |

## Verification
The assertions assume that the pointer changes only through a load or a write. They also assume that `mode` and the bank choice are read only when a byte is accepted, and that reset is held for at least one edge before checking starts. The stimulus drives every input only at the falling edge. It holds reset for several cycles, and it deliberately breaks the usual strobe spacing only in the drop test and the load-redirect test. Because of this, each property relates a state the design reached legitimately to what it shows one cycle later.

// File: rtl/dram_pack_pkg.sv
package dram_pack_pkg;
  typedef enum logic [1:0] {
    MUX_ONE   = 2'd0,
    MUX_TWO   = 2'd1,
    MUX_THREE = 2'd2,
    MUX_FOUR  = 2'd3
  } mux_mode_e;
endpackage

// File: rtl/dram_grp_sel.sv
// Selects the next group of bits from the byte shift register and maps it
// onto memory rows, applying the bank offset in the one- and two-row modes.
module dram_grp_sel
  import dram_pack_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ROWS   = 4,
  parameter int CNT_W  = 4
) (
  input  mux_mode_e          mode,
  input  logic               bank,
  input  logic [BYTE_W-1:0]  sh,
  input  logic [CNT_W-1:0]   bits_left,
  output logic [ROWS-1:0]    en,
  output logic [ROWS-1:0]    data,
  output logic [CNT_W-1:0]   nb,
  output logic [CNT_W-1:0]   gsize
);
  localparam int BANK_OFS = ROWS / 2;

  int base;

  always_comb begin
    gsize = CNT_W'(mode) + CNT_W'(1);
    nb    = (bits_left < gsize) ? bits_left : gsize;
    base  = (bank && (mode == MUX_ONE || mode == MUX_TWO)) ? BANK_OFS : 0;
    en    = '0;
    data  = '0;
    for (int j = 0; j < ROWS; j++) begin
      if (j < int'(nb) && (j + base) < ROWS) begin
        en[j + base]   = 1'b1;
        data[j + base] = sh[BYTE_W-1-j];
      end
    end
  end
endmodule

// File: rtl/dram_ptr.sv
// Column address pointer: a load has priority over a step, and stepping wraps.
module dram_ptr #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] start,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= start;
    else if (adv)  ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/dram_packer.sv
module dram_packer
  import dram_pack_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int ROWS   = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_start,
  input  logic [1:0]        mode,
  input  logic              bank_sel,
  output logic [ROWS-1:0]   wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ROWS-1:0]   wr_data,
  output logic [ADDR_W-1:0] ptr
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  mux_mode_e         mode_q;
  logic              bank_q;
  logic              busy;

  logic [ROWS-1:0]   g_en;
  logic [ROWS-1:0]   g_data;
  logic [CNT_W-1:0]  g_nb;
  logic [CNT_W-1:0]  g_gsize;

  assign busy = (left_q != '0);

  dram_grp_sel #(.BYTE_W(BYTE_W), .ROWS(ROWS), .CNT_W(CNT_W)) u_sel (
    .mode      (mode_q),
    .bank      (bank_q),
    .sh        (sh_q),
    .bits_left (left_q),
    .en        (g_en),
    .data      (g_data),
    .nb        (g_nb),
    .gsize     (g_gsize)
  );

  dram_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .load  (ptr_load),
    .start (ptr_start),
    .adv   (busy),
    .ptr   (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      left_q  <= '0;
      mode_q  <= MUX_ONE;
      bank_q  <= 1'b0;
      wr_en   <= '0;
      wr_data <= '0;
      wr_addr <= '0;
    end else begin
      wr_en   <= '0;
      wr_data <= '0;
      if (busy) begin
        wr_en   <= g_en;
        wr_data <= g_data;
        wr_addr <= ptr;
        sh_q    <= sh_q << g_gsize;
        left_q  <= left_q - g_nb;
      end else if (byte_valid) begin
        sh_q    <= byte_data;
        left_q  <= CNT_W'(BYTE_W);
        mode_q  <= mux_mode_e'(mode);
        bank_q  <= bank_sel;
      end
    end
  end
endmodule

// File: rtl/dram_packer_chk.sv
module dram_packer_chk #(
  parameter int ADDR_W = 5,
  parameter int ROWS   = 4,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ptr_load,
  input logic [ROWS-1:0]   wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] ptr,
  input logic [1:0]        mode_q,
  input logic              bank_q,
  input logic [CNT_W-1:0]  left_q
);
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_en == '0 && ptr == '0));

  p_static_one_r2: assert property (@(posedge clk) disable iff (rst)
    ((|wr_en) && mode_q == 2'd0) |-> ($countones(wr_en) == 1));

  p_no_top_row_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd2) |-> !wr_en[ROWS-1]);

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
    ((|wr_en) && !$past(ptr_load) && !$past(rst)) |-> (ptr == wr_addr + 1'b1));

  p_hold_mode_r10: assert property (@(posedge clk) disable iff (rst)
    (left_q != '0) |=> ($stable(mode_q) && $stable(bank_q)));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (left_q == '0) |=> (wr_en == '0));
endmodule

bind dram_packer dram_packer_chk #(.ADDR_W(ADDR_W), .ROWS(ROWS), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ptr_load (ptr_load),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .ptr      (ptr),
  .mode_q   (mode_q),
  .bank_q   (bank_q),
  .left_q   (left_q)
);

// File: tb/sim_dram_packer.sv
`timescale 1ns/1ps
module sim_dram_packer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       ptr_load = 1'b0;
  logic [4:0] ptr_start = 5'd0;
  logic [1:0] mode = 2'd0;
  logic       bank_sel = 1'b0;
  logic [3:0] wr_en;
  logic [4:0] wr_addr;
  logic [3:0] wr_data;
  logic [4:0] ptr;

  always #2.5 clk = ~clk;

  dram_packer u0 (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .ptr_load(ptr_load), .ptr_start(ptr_start), .mode(mode), .bank_sel(bank_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ptr(ptr)
  );

  typedef struct packed { logic [3:0] en; logic [3:0] data; } grp_t;

  grp_t       q[$];
  bit   [3:0] ref_ram [32];
  bit   [3:0] dut_ram [32];
  int         mptr = 0;
  logic [3:0] exp_en = 4'h0;
  logic [3:0] exp_data = 4'h0;
  int         exp_addr = 0;
  int         nchk = 0;
  int         nerr = 0;
  bit         chk_on = 1'b0;
  bit         done = 1'b0;
  string      tag = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Build the expected writes for one byte from the requirement text.
  task automatic push_byte(input logic [7:0] d, input int md, input bit bk);
    int gs = md + 1;
    int base = (bk && md < 2) ? 2 : 0;
    for (int b = 0; b < 8; b += gs) begin
      grp_t g;
      g = '0;
      for (int j = 0; j < gs; j++)
        if (b + j < 8) begin
          g.en[base + j]   = 1'b1;
          g.data[base + j] = d[7 - b - j];
        end
      q.push_back(g);
    end
  endtask

  // Reference model stepped on each rising edge from the inputs it saw there.
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      mptr = 0;
      exp_en = 4'h0;
      exp_data = 4'h0;
      for (int a = 0; a < 32; a++) ref_ram[a] = 4'h0;
    end else begin
      bit busy;
      busy = (q.size() != 0);
      exp_en = 4'h0;
      exp_data = 4'h0;
      if (busy) begin
        grp_t g;
        g = q.pop_front();
        exp_en = g.en;
        exp_data = g.data;
        exp_addr = mptr;
        for (int r = 0; r < 4; r++)
          if (g.en[r]) ref_ram[mptr][r] = g.data[r];
      end
      if (ptr_load) mptr = int'(ptr_start);
      else if (busy) mptr = (mptr + 1) % 32;
      if (byte_valid && !busy) push_byte(byte_data, int'(mode), bank_sel);
    end
  end

  // Compare on every falling edge; also mirror the DUT writes into a memory.
  always @(negedge clk) begin
    if (rst) begin
      for (int a = 0; a < 32; a++) dut_ram[a] = 4'h0;
    end else if (chk_on) begin
      chk(wr_en === exp_en, tag, "wr_en", int'(wr_en), int'(exp_en));
      chk(wr_data === exp_data, tag, "wr_data", int'(wr_data), int'(exp_data));
      if (exp_en != 0) chk(int'(wr_addr) == exp_addr, tag, "wr_addr", int'(wr_addr), exp_addr);
      chk(int'(ptr) == mptr, "R7", "ptr", int'(ptr), mptr);
      for (int r = 0; r < 4; r++)
        if (wr_en[r] === 1'b1) dut_ram[wr_addr][r] = wr_data[r];
    end
  end

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data = d;
    @(negedge clk);
    byte_valid = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic load(input logic [4:0] a);
    @(negedge clk);
    ptr_load = 1'b1;
    ptr_start = a;
    @(negedge clk);
    ptr_load = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(wr_en == 4'h0, "R1", "wr_en in reset", int'(wr_en), 0);
    chk(ptr == 5'd0, "R1", "ptr in reset", int'(ptr), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_en == 4'h0, "R1", "wr_en after reset", int'(wr_en), 0);
    chk(ptr == 5'd0, "R1", "ptr after reset", int'(ptr), 0);
    chk_on = 1'b1;

    // R2: one row per write
    tag = "R2"; mode = 2'd0; bank_sel = 1'b0;
    load(5'd0); send(8'hA5); send(8'h3C);
    for (int i = 0; i < 3; i++) send(8'(i * 37 + 11));

    // R6: bank in one- and two-row modes
    tag = "R6"; bank_sel = 1'b1; load(5'd4); send(8'hFF); send(8'h5B);
    mode = 2'd1; send(8'hC3);
    bank_sel = 1'b0;

    // R3: two rows per write
    tag = "R3"; mode = 2'd1; load(5'd8); send(8'h96); send(8'h5A); send(8'h0F);

    // R5: four rows per write, fills rows fully for the partial-write test
    tag = "R5"; mode = 2'd3; load(5'd16); send(8'hFF); send(8'hFF); send(8'h4E);

    // R4: three rows, row 3 left alone; bank ignored (R6)
    tag = "R4"; mode = 2'd2; bank_sel = 1'b1; load(5'd16); send(8'h00); send(8'hB6);
    bank_sel = 1'b0;

    // R7: wrap from 31 to 0
    tag = "R7"; mode = 2'd0; load(5'd30); send(8'h81);

    // R8: load together with a strobe
    tag = "R8"; mode = 2'd1;
    @(negedge clk);
    ptr_load = 1'b1; ptr_start = 5'd20; byte_valid = 1'b1; byte_data = 8'h6D;
    @(negedge clk);
    ptr_load = 1'b0; byte_valid = 1'b0;
    repeat (8) @(negedge clk);
    // R8: load during unpacking redirects the rest
    @(negedge clk); mode = 2'd0; byte_valid = 1'b1; byte_data = 8'hE7;
    @(negedge clk); byte_valid = 1'b0;
    repeat (2) @(negedge clk);
    load(5'd26);
    repeat (10) @(negedge clk);

    // R10: mode and bank changes mid-byte are ignored
    tag = "R10"; mode = 2'd0; bank_sel = 1'b0; load(5'd2);
    @(negedge clk); byte_valid = 1'b1; byte_data = 8'h9C;
    @(negedge clk); byte_valid = 1'b0; mode = 2'd3; bank_sel = 1'b1;
    repeat (10) @(negedge clk);
    mode = 2'd0; bank_sel = 1'b0;

    // R11: strobe while writes pending is dropped
    tag = "R11"; mode = 2'd3; load(5'd12);
    @(negedge clk); byte_valid = 1'b1; byte_data = 8'h3A;
    @(negedge clk); byte_data = 8'hC5;
    @(negedge clk); byte_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(int'(ptr) == 14, "R11", "ptr after dropped strobe", int'(ptr), 14);

    // R12: timing of the first write
    tag = "R12"; mode = 2'd1; load(5'd0);
    @(negedge clk); byte_valid = 1'b1; byte_data = 8'h77;
    @(negedge clk); byte_valid = 1'b0;
    chk(wr_en == 4'h0, "R12", "no write one edge after strobe", int'(wr_en), 0);
    @(negedge clk);
    chk(wr_en != 4'h0, "R12", "write two edges after strobe", int'(wr_en), 3);
    repeat (8) @(negedge clk);

    // R9: whole memory matches, untouched bits preserved
    for (int a = 0; a < 32; a++)
      chk(dut_ram[a] == ref_ram[a], "R9", "memory word", int'(dut_ram[a]), int'(ref_ram[a]));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule